// File: doc/BRIEF.md
# Round-Robin DMA Bus Master Arbiter

This block chooses which internal DMA source gets the shared bus master next. Three sources take turns in a fixed rotation: a memory-management fetch unit, a register-program sequencer and the oldest entry of a data-channel queue. Data channels join that queue in arrival order, and each channel can hold at most one entry. Whenever any source has work, the block pulls its active-low bus request low. When the active-low grant arrives, the block opens a burst for the selected source and counts accepted Dwords until the burst length is reached. It then gives the next turn to the following source in the rotation.

The two system sources always use fixed burst lengths. Each data channel takes its length from its own field of a packed burst-length bus. A target retry ends the current burst early. For a data channel, the retry raises a per-channel retry flag and leaves the queue entry in place, so the channel is served again on its next data turn. Each channel's software transfer enable is copied into an internal shadow. Clearing an enable therefore cannot abandon a retried transfer: the retried transfer runs to completion before the cleared enable is acted on.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted, `req_n` is 1, `xfer_busy` is 0 and `retry_pend` is all zero.
- R2: `req_n` is 0 whenever at least one of the following holds, and 1 otherwise: `mmu_req` is high, `seq_req` is high, a serviceable queue entry exists, or a burst is in progress.
- R3: A burst starts only at a clock edge where `gnt_n` is 0. While `gnt_n` is 1, `dw_ack` and `retry` are ignored and an open burst stays open.
- R4: Turns rotate in the order MMU (`xfer_src`=0), then sequencer (1), then data (2), then back to MMU. Sources with nothing pending are skipped within the same cycle. Each data turn serves exactly one entry, the oldest one.
- R5: An MMU burst ends after 2 accepted Dwords. A sequencer burst ends after 4 accepted Dwords.
- R6: The burst length of data channel i is read from `burst_len[i*BLW +: BLW]` when the burst starts. A field value of 0 means 2^BLW Dwords.
- R7: A channel that has `ch_want` high, has its shadow enable set and has no entry in the queue gains one entry. At most one channel gains an entry per cycle, and the lowest index goes first. Entries are served in the order they were added.
- R8: A `retry` ends the burst at once. For a data channel, the retry sets that channel's `retry_pend` bit and keeps its entry. A burst that completes without a retry clears the bit and removes the entry.
- R9: Clearing `ch_en` has no effect while that channel has a retry pending, so the retried transfer still completes. An oldest entry whose enable is cleared and which has no retry pending is discarded without a burst.
- R10: `xfer_busy` rises one cycle after the edge that samples the grant. It falls at the edge that accepts the final Dword or the retry. At least one idle cycle separates two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_req | input | 1 | Memory-management fetch unit has work |
| seq_req | input | 1 | Register-program sequencer has work |
| ch_want | input | NCH | Per data channel: FIFO level warrants a transfer |
| ch_en | input | NCH | Per data channel software transfer enable |
| burst_len | input | NCH*BLW | Packed per-channel burst lengths, 0 meaning 2^BLW |
| gnt_n | input | 1 | Active-low bus grant |
| dw_ack | input | 1 | One Dword of the current burst was transferred |
| retry | input | 1 | Target retry ended the current burst |
| req_n | output | 1 | Active-low bus request |
| xfer_busy | output | 1 | A burst is open |
| xfer_src | output | 2 | Source of the open burst: 0 MMU, 1 sequencer, 2 data |
| xfer_ch | output | $clog2(NCH) | Data channel of the open burst (0 for system sources) |
| retry_pend | output | NCH | Per-channel retry-pending flags |

## Verification
Random rounds hold the two system requests steady and load a shuffled subset of the data channels with random burst lengths, including zero. Under these rounds a wrong rotation, a wrong skip or a broken queue order shows up as the wrong source or channel at the start of a burst. Random retries inserted at random Dword positions separate "entry kept and re-served" from "entry dropped". Directed cases cover Dword acknowledgements while the grant is withheld, a simultaneous entry by two channels, a zero length field, and clearing an enable in two situations: with a retry pending and without one. These cases show whether the shadowed enable protects exactly the retried channel.

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NCH = 8,
  parameter int BLW = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mmu_req,
  input  logic               seq_req,
  input  logic [NCH-1:0]     ch_want,
  input  logic [NCH-1:0]     ch_en,
  input  logic [NCH*BLW-1:0] burst_len,
  input  logic               gnt_n,
  input  logic               dw_ack,
  input  logic               retry,
  output logic               req_n,
  output logic               xfer_busy,
  output logic [1:0]         xfer_src,
  output logic [CW-1:0]      xfer_ch,
  output logic [NCH-1:0]     retry_pend
);
  localparam int LW = BLW + 1;
  localparam int MMU_BURST = 2;
  localparam int SEQ_BURST = 4;
  localparam logic [1:0] SRC_MMU = 2'd0;
  localparam logic [1:0] SRC_SEQ = 2'd1;
  localparam logic [1:0] SRC_DAT = 2'd2;

  logic [CW-1:0]  q_mem [NCH];
  logic [CW-1:0]  q_hd, q_tl;
  logic [CW:0]    q_cnt;
  logic [NCH-1:0] queued, en_sh;
  logic [1:0]     turn, src, pick;
  logic [CW-1:0]  ch, enq_ch;
  logic [LW-1:0]  len, cnt;
  logic           busy, pick_v, enq_v;

  wire           own    = !gnt_n;
  wire           q_ne   = q_cnt != '0;
  wire [CW-1:0]  hd_ch  = q_mem[q_hd];
  wire           hd_rp  = retry_pend[hd_ch];
  wire           dat_ok = q_ne && (en_sh[hd_ch] || hd_rp);
  wire [2:0]     pend   = {dat_ok, seq_req, mmu_req};
  wire [BLW-1:0] fld    = burst_len[int'(hd_ch)*BLW +: BLW];
  wire [NCH-1:0] cand   = ch_want & en_sh & ~queued;

  always_comb begin
    pick   = SRC_MMU;
    pick_v = 1'b0;
    for (int k = 2; k >= 0; k--) begin
      int s;
      s = (int'(turn) + k) % 3;
      if (pend[s]) begin
        pick   = 2'(s);
        pick_v = 1'b1;
      end
    end
  end

  always_comb begin
    enq_v  = 1'b0;
    enq_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        enq_v  = 1'b1;
        enq_ch = CW'(i);
      end
    end
  end

  wire start  = !busy && own && pick_v;
  wire acc    = busy && own && dw_ack && !retry;
  wire rty    = busy && own && retry;
  wire fin_ok = acc && (cnt == len - LW'(1));
  wire fin    = fin_ok || rty;
  wire drop   = q_ne && !en_sh[hd_ch] && !hd_rp && !(busy && src == SRC_DAT);
  wire deq    = (fin_ok && src == SRC_DAT) || drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) q_mem[i] <= '0;
      q_hd       <= '0;
      q_tl       <= '0;
      q_cnt      <= '0;
      queued     <= '0;
      en_sh      <= '0;
      retry_pend <= '0;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (!retry_pend[i]) en_sh[i] <= ch_en[i];
      if (enq_v) begin
        q_mem[q_tl]    <= enq_ch;
        q_tl           <= (q_tl == CW'(NCH - 1)) ? '0 : q_tl + 1'b1;
        queued[enq_ch] <= 1'b1;
      end
      if (deq) begin
        q_hd          <= (q_hd == CW'(NCH - 1)) ? '0 : q_hd + 1'b1;
        queued[hd_ch] <= 1'b0;
      end
      q_cnt <= q_cnt + {{CW{1'b0}}, enq_v} - {{CW{1'b0}}, deq};
      if (rty && src == SRC_DAT) retry_pend[ch] <= 1'b1;
      if (fin_ok && src == SRC_DAT) retry_pend[ch] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      turn <= SRC_MMU;
      src  <= SRC_MMU;
      ch   <= '0;
      len  <= '0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      src  <= pick;
      ch   <= (pick == SRC_DAT) ? hd_ch : '0;
      cnt  <= '0;
      case (pick)
        SRC_MMU: len <= LW'(MMU_BURST);
        SRC_SEQ: len <= LW'(SEQ_BURST);
        default: len <= {~|fld, fld};
      endcase
    end else if (fin) begin
      busy <= 1'b0;
      turn <= (src == SRC_DAT) ? SRC_MMU : src + 2'd1;
    end else if (acc) begin
      cnt <= cnt + LW'(1);
    end
  end

  assign req_n     = !(busy || |pend);
  assign xfer_busy = busy;
  assign xfer_src  = src;
  assign xfer_ch   = ch;
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           gnt_n,
  input logic           dw_ack,
  input logic           retry,
  input logic           xfer_busy,
  input logic [1:0]     xfer_src,
  input logic [CW-1:0]  xfer_ch,
  input logic [NCH-1:0] retry_pend
);
  logic [NCH-1:0] oh_q;
  logic [7:0]     acks;

  always_ff @(posedge clk) begin
    oh_q <= NCH'(1) << xfer_ch;
    if (!rst_n || !xfer_busy) acks <= '0;
    else if (!gnt_n && dw_ack && !retry) acks <= acks + 8'd1;
  end

  always @(posedge clk) begin
    if (rst_n && xfer_busy && !gnt_n && dw_ack && !retry) begin
      if (xfer_src == 2'd0) assert_mmu_len_R5: assert (acks < 8'd2);
      if (xfer_src == 2'd1) assert_seq_len_R5: assert (acks < 8'd4);
    end
  end

  assert_start_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_busy) |-> !$past(gnt_n));

  assert_hold_without_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && gnt_n) |=> xfer_busy);

  assert_src_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> (!xfer_busy || ($stable(xfer_src) && $stable(xfer_ch))));

  assert_retry_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !gnt_n && retry && xfer_src == 2'd2) |=> |(retry_pend & oh_q));
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_n(gnt_n), .dw_ack(dw_ack), .retry(retry),
  .xfer_busy(xfer_busy), .xfer_src(xfer_src), .xfer_ch(xfer_ch),
  .retry_pend(retry_pend)
);

// File: tb/dma_bus_arbiter_bench.sv
module dma_bus_arbiter_bench;
  localparam int NCH = 8;
  localparam int BLW = 4;
  localparam int CW  = $clog2(NCH);

  logic clk = 1'b0;
  logic rst_n, mmu_req, seq_req, gnt_n, dw_ack, retry;
  logic [NCH-1:0] ch_want, ch_en;
  logic [NCH*BLW-1:0] burst_len;
  logic req_n, xfer_busy;
  logic [1:0] xfer_src;
  logic [CW-1:0] xfer_ch;
  logic [NCH-1:0] retry_pend;

  int n_chk = 0, n_bad = 0;
  int mq[$];
  int mturn = 0;
  bit [NCH-1:0] mrp = '0;

  always #2.5 clk = ~clk;

  dma_bus_arbiter #(.NCH(NCH), .BLW(BLW)) u_dma_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .mmu_req(mmu_req), .seq_req(seq_req),
    .ch_want(ch_want), .ch_en(ch_en), .burst_len(burst_len), .gnt_n(gnt_n),
    .dw_ack(dw_ack), .retry(retry), .req_n(req_n), .xfer_busy(xfer_busy),
    .xfer_src(xfer_src), .xfer_ch(xfer_ch), .retry_pend(retry_pend)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff_len(int c);
    int v;
    v = int'(burst_len[c*BLW +: BLW]);
    return (v == 0) ? (1 << BLW) : v;
  endfunction

  function automatic int next_src();
    for (int k = 0; k < 3; k++) begin
      int s;
      bit p;
      s = (mturn + k) % 3;
      p = (s == 0) ? mmu_req : (s == 1) ? seq_req : (mq.size() > 0);
      if (p) return s;
    end
    return -1;
  endfunction

  task automatic pulse(int c);
    ch_want[c] = 1'b1;
    @(negedge clk);
    ch_want[c] = 1'b0;
    mq.push_back(c);
  endtask

  // mode 0: random retry, 1: clean, 2: forced retry
  task automatic serve(int mode);
    int s, c, L, k;
    bit r, early;
    s = next_src();
    c = (s == 2) ? mq[0] : 0;
    for (int w = 0; w < 6 && !xfer_busy; w++) @(negedge clk);
    check("R4 burst opened", int'(xfer_busy), 1);
    if (!xfer_busy) return;
    check("R4 rotation source", int'(xfer_src), s);
    if (s == 2) check("R7 queue order channel", int'(xfer_ch), c);
    L = (s == 0) ? 2 : (s == 1) ? 4 : eff_len(c);
    r = (mode == 2) ? 1'b1 : (mode == 1) ? 1'b0 : ($urandom_range(0, 3) == 0);
    k = r ? $urandom_range(0, L - 1) : L;
    early = 1'b0;
    for (int j = 0; j < k; j++) begin
      if (!xfer_busy) early = 1'b1;
      dw_ack = 1'b1;
      @(negedge clk);
    end
    dw_ack = 1'b0;
    if (r) begin
      if (!xfer_busy) early = 1'b1;
      retry = 1'b1;
      @(negedge clk);
      retry = 1'b0;
    end
    check((s == 2) ? "R6 data burst not cut short" : "R5 system burst not cut short", int'(early), 0);
    check(r ? "R8 retry ends burst" : ((s == 2) ? "R6 data burst ends" : "R5 system burst ends"),
          int'(xfer_busy), 0);
    mturn = (s + 1) % 3;
    if (s == 2) begin
      if (r) mrp[c] = 1'b1;
      else begin
        void'(mq.pop_front());
        mrp[c] = 1'b0;
      end
    end
    check("R8 retry flags", int'(retry_pend), int'(mrp));
  endtask

  task automatic run_all();
    int perm[NCH];
    rst_n = 1'b0; mmu_req = 1'b0; seq_req = 1'b0; gnt_n = 1'b1;
    dw_ack = 1'b0; retry = 1'b0; ch_want = '0; ch_en = '1;
    for (int i = 0; i < NCH; i++) burst_len[i*BLW +: BLW] = BLW'(3);
    repeat (3) @(negedge clk);
    check("R1 req_n in reset", int'(req_n), 1);
    check("R1 busy in reset", int'(xfer_busy), 0);
    check("R1 retry flags in reset", int'(retry_pend), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    mmu_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 request with grant withheld", int'(req_n), 0);
    check("R3 no start without grant", int'(xfer_busy), 0);
    gnt_n = 1'b0;
    @(negedge clk);
    check("R10 busy one cycle after grant", int'(xfer_busy), 1);
    check("R4 MMU first", int'(xfer_src), 0);
    gnt_n = 1'b1; dw_ack = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 acks ignored without grant", int'(xfer_busy), 1);
    gnt_n = 1'b0;
    @(negedge clk);
    check("R5 MMU open after one Dword", int'(xfer_busy), 1);
    @(negedge clk);
    dw_ack = 1'b0;
    check("R5 MMU ends after two Dwords", int'(xfer_busy), 0);
    mmu_req = 1'b0;
    mturn = 1;
    #1 check("R2 request released", int'(req_n), 1);
    @(negedge clk);

    gnt_n = 1'b1;
    ch_want[2] = 1'b1; ch_want[1] = 1'b1;
    repeat (2) @(negedge clk);
    ch_want = '0;
    mq.push_back(1); mq.push_back(2);
    gnt_n = 1'b0;
    serve(1);
    serve(1);
    check("R7 queue drained", int'(req_n), 1);

    gnt_n = 1'b1;
    pulse(3);
    gnt_n = 1'b0;
    serve(2);
    gnt_n = 1'b1;
    ch_en[3] = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 retried entry kept despite cleared enable", int'(req_n), 0);
    check("R9 retry flag held", int'(retry_pend[3]), 1);
    gnt_n = 1'b0;
    serve(1);
    check("R9 nothing left after retried transfer", int'(req_n), 1);
    ch_en[3] = 1'b1;
    repeat (2) @(negedge clk);

    gnt_n = 1'b1;
    pulse(5);
    pulse(6);
    ch_en[5] = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 later entry still pending", int'(req_n), 0);
    void'(mq.pop_front());
    gnt_n = 1'b0;
    serve(1);
    check("R9 disabled head discarded", int'(req_n), 1);
    ch_en[5] = 1'b1;
    repeat (2) @(negedge clk);

    burst_len[4*BLW +: BLW] = '0;
    gnt_n = 1'b1;
    pulse(4);
    gnt_n = 1'b0;
    serve(1);
    repeat (2) @(negedge clk);

    for (int rd = 0; rd < 40; rd++) begin
      int n;
      gnt_n = 1'b1;
      mmu_req = 1'($urandom_range(0, 1));
      seq_req = 1'($urandom_range(0, 1));
      for (int i = 0; i < NCH; i++) burst_len[i*BLW +: BLW] = BLW'($urandom_range(0, 15));
      for (int i = 0; i < NCH; i++) perm[i] = i;
      for (int i = NCH - 1; i > 0; i--) begin
        int j, t;
        j = $urandom_range(0, i);
        t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      n = $urandom_range(1, NCH);
      for (int i = 0; i < n; i++) pulse(perm[i]);
      @(negedge clk);
      check("R2 request while loaded", int'(req_n), 0);
      gnt_n = 1'b0;
      while (mq.size() > 0) begin
        serve(0);
        if (mq.size() == 0) begin
          mmu_req = 1'b0;
          seq_req = 1'b0;
        end
      end
      #1 check("R2 request released after round", int'(req_n), 1);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule